// File: doc/BRIEF.md
# Prefetching Read Request Generator

This block sits on the target-side bus of a bridge. It turns one queued delayed read into a speculative memory read burst. For each accepted request it decides whether the read may be prefetched, from the command code and a flag that marks a prefetchable range. It then works out how many Dwords to fetch. The master request it issues carries the length, the byte enables and the 64-bit request. The returned data goes into a read data queue through a write port.

The length follows a few rules:

- A cache-line read fetches up to the end of the current cache line.
- A multiple-line read, or a plain read that hits a prefetchable range, fetches up to the end of a block of 2^MULT_LOG2 lines.
- In streaming (flow-through) mode the fetch runs up to the address boundary.
- Every length is clipped at a 4 KB boundary. For a streaming read that hits the second upstream window, the limit is a larger page boundary instead.

Data phases stop while the queue reports almost-full and start again when it clears.

Top module: `pf_read_gen`

## Requirements
- R1: A request is prefetchable when its command is 4'hE (read line) or 4'hC (read multiple), or when it is 4'h6 (plain read) with `req_pf_range` set. Every other case is a single-Dword read.
- R2: For a prefetchable request, `m_be` is 4'h0 (all bytes enabled), whatever `req_be` holds.
- R3: `m_req64` is 1 exactly when the request is prefetchable and address bit 2 is 0.
- R4: When `m_req64` and `m_ack64` are both 1, each data phase writes two Dwords to the queue in one write with `q_wdw2`=1. The lower address is in bits 31:0 and the next Dword is in bits 63:32. Outside almost-full, `m_irdy` stays 1 on every data cycle, so the master adds no wait states.
- R5: A fetch never crosses a 4 KB boundary (BND_LOG2=12). A streaming read outside the second window fetches exactly up to that boundary.
- R6: A streaming read with `req_mr2` set fetches up to the next page boundary, PAGE_LOG2=14 (16 KB), instead of 4 KB.
- R7: A non-streaming read-line request fetches up to the next boundary of a line of 2^`req_cls_log2` Dwords.
- R8: A non-streaming read-multiple request, or a prefetchable plain read, fetches up to the next boundary of 2^MULT_LOG2 lines (MULT_LOG2=1).
- R9: While `q_afull` is 1, `m_irdy` is 0 and `q_wr` is 0. Data phases resume once it returns to 0.
- R10: A non-prefetchable request fetches exactly one Dword, passes `req_be` to `m_be` and keeps `m_req64` at 0.
- R11: The queue receives exactly `m_dwords` Dwords, in ascending address order. A last phase that has a single Dword left writes it with `q_wdw2`=0.
- R12: After reset `req_ready` is 1 and `m_frame`, `m_start` and `q_wr` are 0. A request is accepted only while idle. `m_start` pulses for one cycle in the cycle after acceptance, and `req_ready` returns after the last Dword.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Delayed read request present |
| req_ready | output | 1 | Generator idle, request taken |
| req_cmd | input | 4 | Bus command of the read |
| req_addr | input | ADDR_W | Byte start address |
| req_be | input | 4 | Initiator byte enables, active low |
| req_pf_range | input | 1 | Address hits a prefetchable range |
| req_mr2 | input | 1 | Upstream read in the second memory window |
| req_cls_log2 | input | 3 | Log2 of the initiator cache line in Dwords |
| req_flow | input | 1 | Streaming mode active |
| m_start | output | 1 | One-cycle address phase strobe |
| m_frame | output | 1 | Master transaction in progress |
| m_cmd | output | 4 | Command issued |
| m_addr | output | ADDR_W | Dword-aligned start address |
| m_be | output | 4 | Byte enables for all data phases |
| m_req64 | output | 1 | 64-bit transfer request |
| m_dwords | output | LEN_W | Dwords to fetch |
| m_irdy | output | 1 | Master ready for a data phase |
| m_trdy | input | 1 | Target delivers data this cycle |
| m_ack64 | input | 1 | Target agreed to 64-bit phases |
| m_data | input | 64 | Read data from the target |
| q_wr | output | 1 | Queue write strobe |
| q_wdata | output | 64 | Queue write data |
| q_wdw2 | output | 1 | Both Dwords of this write are valid |
| q_afull | input | 1 | Queue almost full |

## Verification
The assertions check on every cycle the properties that hold phase by phase:

- no queue write and no master ready while almost-full;
- 64-bit requests only from aligned starts with all byte enables active;
- double-Dword writes only under an acknowledged 64-bit transfer;
- no burst that spans the 4 KB or page limit;
- the one-cycle start strobe after acceptance and the idle return after the final Dword.

The length rules for each command, cache line size and mode cannot be read from one cycle. Neither can the exact Dword count, the data order and the single-Dword last phase. Only the bench's scenarios show these, comparing each transfer with lengths and data computed from the request fields.

// File: rtl/pfr_pkg.sv
package pfr_pkg;

    localparam logic [3:0] CMD_RD       = 4'h6;
    localparam logic [3:0] CMD_RD_MULTI = 4'hC;
    localparam logic [3:0] CMD_RD_LINE  = 4'hE;

    typedef enum logic [1:0] {
        PF_NONE,
        PF_LINE,
        PF_MULTI
    } pf_kind_e;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_ADDR,
        ST_DATA
    } xfer_state_e;

endpackage

// File: rtl/pfr_classify.sv
module pfr_classify
    import pfr_pkg::*;
(
    input  logic [3:0] cmd,
    input  logic       pf_range,
    input  logic       addr_bit2,
    input  logic [3:0] be_in,
    output pf_kind_e   kind,
    output logic       req64,
    output logic [3:0] be_out
);

    always_comb begin
        kind = PF_NONE;
        if (cmd == CMD_RD_LINE) begin
            kind = PF_LINE;
        end else if (cmd == CMD_RD_MULTI || (cmd == CMD_RD && pf_range)) begin
            kind = PF_MULTI;
        end
        req64  = (kind != PF_NONE) && !addr_bit2;
        be_out = (kind == PF_NONE) ? be_in : 4'h0;
    end

endmodule

// File: rtl/pfr_len_calc.sv
module pfr_len_calc
    import pfr_pkg::*;
#(
    parameter int BND_LOG2  = 12,
    parameter int PAGE_LOG2 = 14,
    parameter int MULT_LOG2 = 1,
    parameter int LEN_W     = PAGE_LOG2 - 1
) (
    input  logic [PAGE_LOG2-3:0] dw_off,
    input  pf_kind_e             kind,
    input  logic [2:0]           cls_log2,
    input  logic                 flow,
    input  logic                 mr2,
    output logic [LEN_W-1:0]     len
);

    localparam int BND_DW  = 1 << (BND_LOG2 - 2);
    localparam int PAGE_DW = 1 << (PAGE_LOG2 - 2);

    logic [LEN_W-1:0] off_bnd;
    logic [LEN_W-1:0] dist_bnd;
    logic [LEN_W-1:0] off_page;
    logic [LEN_W-1:0] dist_page;
    logic [LEN_W-1:0] limit;
    logic [LEN_W-1:0] line_dw;
    logic [LEN_W-1:0] chunk;
    logic [LEN_W-1:0] off_chunk;
    logic [LEN_W-1:0] dist_chunk;

    always_comb begin
        off_bnd    = LEN_W'(dw_off[BND_LOG2-3:0]);
        dist_bnd   = LEN_W'(BND_DW) - off_bnd;
        off_page   = LEN_W'(dw_off);
        dist_page  = LEN_W'(PAGE_DW) - off_page;
        limit      = (flow && mr2) ? dist_page : dist_bnd;
        line_dw    = LEN_W'(1) << cls_log2;
        chunk      = (kind == PF_LINE) ? line_dw : (line_dw << MULT_LOG2);
        off_chunk  = LEN_W'(dw_off) & (chunk - LEN_W'(1));
        dist_chunk = chunk - off_chunk;
        if (kind == PF_NONE) begin
            len = LEN_W'(1);
        end else if (flow) begin
            len = limit;
        end else begin
            len = (dist_chunk < limit) ? dist_chunk : limit;
        end
    end

endmodule

// File: rtl/pfr_xfer_ctrl.sv
module pfr_xfer_ctrl
    import pfr_pkg::*;
#(
    parameter int ADDR_W   = 32,
    parameter int LEN_W    = 13,
    parameter int BND_LOG2 = 12
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic [3:0]        ld_cmd,
    input  logic [ADDR_W-1:0] ld_addr,
    input  logic [3:0]        ld_be,
    input  logic              ld_req64,
    input  logic              ld_page,
    input  logic [LEN_W-1:0]  ld_len,
    output logic              m_start,
    output logic              m_frame,
    output logic [3:0]        m_cmd,
    output logic [ADDR_W-1:0] m_addr,
    output logic [3:0]        m_be,
    output logic              m_req64,
    output logic [LEN_W-1:0]  m_dwords,
    output logic              m_irdy,
    input  logic              m_trdy,
    input  logic              m_ack64,
    input  logic [63:0]       m_data,
    output logic              q_wr,
    output logic [63:0]       q_wdata,
    output logic              q_wdw2,
    input  logic              q_afull
);

    localparam int BND_DW = 1 << (BND_LOG2 - 2);

    typedef struct packed {
        xfer_state_e       st;
        logic [ADDR_W-1:0] addr;
        logic [3:0]        cmd;
        logic [3:0]        be;
        logic              req64;
        logic              page;
        logic [LEN_W-1:0]  len;
        logic [LEN_W-1:0]  rem;
    } ctrl_t;

    ctrl_t ctl_d;
    ctrl_t ctl_q;
    logic  two_dw;

    always_comb begin
        ctl_d     = ctl_q;
        req_ready = (ctl_q.st == ST_IDLE);
        m_start   = (ctl_q.st == ST_ADDR);
        m_frame   = (ctl_q.st != ST_IDLE);
        m_irdy    = (ctl_q.st == ST_DATA) && !q_afull;
        two_dw    = ctl_q.req64 && m_ack64 && (ctl_q.rem >= LEN_W'(2));
        q_wr      = m_irdy && m_trdy;
        q_wdw2    = q_wr && two_dw;
        q_wdata   = m_data;
        case (ctl_q.st)
            ST_IDLE: begin
                if (req_valid) begin
                    ctl_d.st    = ST_ADDR;
                    ctl_d.addr  = {ld_addr[ADDR_W-1:2], 2'b00};
                    ctl_d.cmd   = ld_cmd;
                    ctl_d.be    = ld_be;
                    ctl_d.req64 = ld_req64;
                    ctl_d.page  = ld_page;
                    ctl_d.len   = ld_len;
                    ctl_d.rem   = ld_len;
                end
            end
            ST_ADDR: begin
                ctl_d.st = ST_DATA;
            end
            ST_DATA: begin
                if (q_wr) begin
                    ctl_d.rem = ctl_q.rem - (two_dw ? LEN_W'(2) : LEN_W'(1));
                    if (ctl_d.rem == '0) begin
                        ctl_d.st = ST_IDLE;
                    end
                end
            end
            default: begin
                ctl_d.st = ST_IDLE;
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctl_q <= '{st: ST_IDLE, addr: '0, cmd: '0, be: '0, req64: 1'b0,
                       page: 1'b0, len: '0, rem: '0};
        end else begin
            ctl_q <= ctl_d;
        end
    end

    assign m_cmd    = ctl_q.cmd;
    assign m_addr   = ctl_q.addr;
    assign m_be     = ctl_q.be;
    assign m_req64  = ctl_q.req64;
    assign m_dwords = ctl_q.len;

    AST_START_AFTER_ACCEPT: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready) |=> m_start);                                  // R12
    AST_START_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        m_start |=> !m_start);                                                  // R12
    AST_BE_ALL_ON: assert property (@(posedge clk) disable iff (!rst_n)
        (m_start && m_req64) |-> (m_be == 4'h0));                               // R2
    AST_REQ64_ALIGNED: assert property (@(posedge clk) disable iff (!rst_n)
        (m_start && m_req64) |-> !m_addr[2]);                                   // R3
    AST_NO_WR_AFULL: assert property (@(posedge clk) disable iff (!rst_n)
        q_afull |-> (!q_wr && !m_irdy));                                        // R9
    AST_WIDE_NEEDS_ACK: assert property (@(posedge clk) disable iff (!rst_n)
        q_wdw2 |-> (m_req64 && m_ack64));                                       // R4
    AST_BND_4K: assert property (@(posedge clk) disable iff (!rst_n)
        (m_start && !ctl_q.page) |->
        ((LEN_W'(m_addr[BND_LOG2-1:2]) + m_dwords) <= LEN_W'(BND_DW)));         // R5
    AST_END_AT_LAST: assert property (@(posedge clk) disable iff (!rst_n)
        (q_wr && ((q_wdw2 && ctl_q.rem == LEN_W'(2)) ||
                  (!q_wdw2 && ctl_q.rem == LEN_W'(1)))) |=> !m_frame);          // R11

endmodule

// File: rtl/pf_read_gen.sv
module pf_read_gen
    import pfr_pkg::*;
#(
    parameter int ADDR_W    = 32,
    parameter int BND_LOG2  = 12,
    parameter int PAGE_LOG2 = 14,
    parameter int MULT_LOG2 = 1,
    parameter int LEN_W     = PAGE_LOG2 - 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic [3:0]        req_cmd,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [3:0]        req_be,
    input  logic              req_pf_range,
    input  logic              req_mr2,
    input  logic [2:0]        req_cls_log2,
    input  logic              req_flow,
    output logic              m_start,
    output logic              m_frame,
    output logic [3:0]        m_cmd,
    output logic [ADDR_W-1:0] m_addr,
    output logic [3:0]        m_be,
    output logic              m_req64,
    output logic [LEN_W-1:0]  m_dwords,
    output logic              m_irdy,
    input  logic              m_trdy,
    input  logic              m_ack64,
    input  logic [63:0]       m_data,
    output logic              q_wr,
    output logic [63:0]       q_wdata,
    output logic              q_wdw2,
    input  logic              q_afull
);

    localparam int PAGE_DW = 1 << (PAGE_LOG2 - 2);

    pf_kind_e         kind;
    logic             cls_req64;
    logic [3:0]       cls_be;
    logic [LEN_W-1:0] calc_len;

    pfr_classify u_classify (
        .cmd       (req_cmd),
        .pf_range  (req_pf_range),
        .addr_bit2 (req_addr[2]),
        .be_in     (req_be),
        .kind      (kind),
        .req64     (cls_req64),
        .be_out    (cls_be)
    );

    pfr_len_calc #(
        .BND_LOG2  (BND_LOG2),
        .PAGE_LOG2 (PAGE_LOG2),
        .MULT_LOG2 (MULT_LOG2),
        .LEN_W     (LEN_W)
    ) u_len_calc (
        .dw_off   (req_addr[PAGE_LOG2-1:2]),
        .kind     (kind),
        .cls_log2 (req_cls_log2),
        .flow     (req_flow),
        .mr2      (req_mr2),
        .len      (calc_len)
    );

    pfr_xfer_ctrl #(
        .ADDR_W   (ADDR_W),
        .LEN_W    (LEN_W),
        .BND_LOG2 (BND_LOG2)
    ) u_xfer_ctrl (
        .clk       (clk),
        .rst_n     (rst_n),
        .req_valid (req_valid),
        .req_ready (req_ready),
        .ld_cmd    (req_cmd),
        .ld_addr   (req_addr),
        .ld_be     (cls_be),
        .ld_req64  (cls_req64),
        .ld_page   (req_flow && req_mr2),
        .ld_len    (calc_len),
        .m_start   (m_start),
        .m_frame   (m_frame),
        .m_cmd     (m_cmd),
        .m_addr    (m_addr),
        .m_be      (m_be),
        .m_req64   (m_req64),
        .m_dwords  (m_dwords),
        .m_irdy    (m_irdy),
        .m_trdy    (m_trdy),
        .m_ack64   (m_ack64),
        .m_data    (m_data),
        .q_wr      (q_wr),
        .q_wdata   (q_wdata),
        .q_wdw2    (q_wdw2),
        .q_afull   (q_afull)
    );

    AST_PAGE_LIMIT: assert property (@(posedge clk) disable iff (!rst_n)
        m_start |-> ((LEN_W'(m_addr[PAGE_LOG2-1:2]) + m_dwords) <= LEN_W'(PAGE_DW)));  // R6
    AST_LEN_NONZERO: assert property (@(posedge clk) disable iff (!rst_n)
        m_start |-> (m_dwords != '0));                                                  // R11

endmodule

// File: tb/pf_read_gen_tb_top.sv
module pf_read_gen_tb_top;

    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic        req_ready;
    logic [3:0]  req_cmd = 4'h0;
    logic [31:0] req_addr = '0;
    logic [3:0]  req_be = 4'h0;
    logic        req_pf_range = 1'b0;
    logic        req_mr2 = 1'b0;
    logic [2:0]  req_cls_log2 = 3'd0;
    logic        req_flow = 1'b0;
    logic        m_start;
    logic        m_frame;
    logic [3:0]  m_cmd;
    logic [31:0] m_addr;
    logic [3:0]  m_be;
    logic        m_req64;
    logic [12:0] m_dwords;
    logic        m_irdy;
    logic        m_trdy = 1'b0;
    logic        m_ack64 = 1'b0;
    logic [63:0] m_data = '0;
    logic        q_wr;
    logic [63:0] q_wdata;
    logic        q_wdw2;
    logic        q_afull = 1'b0;

    int  checks = 0;
    int  errors = 0;
    bit  summary_done = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    pf_read_gen dut_i (
        .clk(clk), .rst_n(rst_n),
        .req_valid(req_valid), .req_ready(req_ready), .req_cmd(req_cmd),
        .req_addr(req_addr), .req_be(req_be), .req_pf_range(req_pf_range),
        .req_mr2(req_mr2), .req_cls_log2(req_cls_log2), .req_flow(req_flow),
        .m_start(m_start), .m_frame(m_frame), .m_cmd(m_cmd), .m_addr(m_addr),
        .m_be(m_be), .m_req64(m_req64), .m_dwords(m_dwords), .m_irdy(m_irdy),
        .m_trdy(m_trdy), .m_ack64(m_ack64), .m_data(m_data),
        .q_wr(q_wr), .q_wdata(q_wdata), .q_wdw2(q_wdw2), .q_afull(q_afull)
    );

    task automatic chk(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    function automatic int kind_of(input logic [3:0] cmd, input bit pf);
        if (cmd == 4'hE) return 1;
        if (cmd == 4'hC || (cmd == 4'h6 && pf)) return 2;
        return 0;
    endfunction

    function automatic int len_of(input int kind, input logic [31:0] addr,
                                  input int cls, input bit flow, input bit mr2);
        int dw    = int'(addr[13:2]);
        int lim   = (flow && mr2) ? 4096 - dw : 1024 - (dw % 1024);
        int chunk = (1 << cls) * ((kind == 1) ? 1 : 2);
        int dc    = chunk - (dw % chunk);
        if (kind == 0) return 1;
        if (flow) return lim;
        return (dc < lim) ? dc : lim;
    endfunction

    function automatic logic [31:0] data_of(input logic [31:0] dw);
        return (dw * 32'h9E37_79B1) ^ 32'h5A5A_0000;
    endfunction

    task automatic run_txn(input logic [3:0] cmd, input logic [31:0] addr,
                           input logic [3:0] be, input bit pf, input bit mr2,
                           input int cls, input bit flow, input bit ack,
                           input int afull_pct, input int trdy_pct, input string ltag);
        int          kind = kind_of(cmd, pf);
        int          elen = len_of(kind, addr, cls, flow, mr2);
        bit          e64  = (kind != 0) && !addr[2];
        bit          use64 = e64 && ack;
        logic [31:0] dw0  = {2'b00, addr[31:2]};
        int          idx  = 0;
        int          cyc  = 0;
        @(negedge clk);
        req_valid = 1'b1; req_cmd = cmd; req_addr = addr; req_be = be;
        req_pf_range = pf; req_mr2 = mr2; req_cls_log2 = 3'(cls); req_flow = flow;
        #1;
        chk(req_ready == 1'b1, "R12", "ready while idle", req_ready, 1);
        @(negedge clk);
        req_valid = 1'b0;
        #1;
        chk(m_start == 1'b1, "R12", "start strobe", m_start, 1);
        chk(m_dwords == 13'(elen), ltag, "fetch length", m_dwords, elen);
        chk(m_req64 == e64, "R3", "req64", m_req64, e64);
        chk(m_be == ((kind == 0) ? be : 4'h0), (kind == 0) ? "R10" : "R2", "byte enables",
            m_be, (kind == 0) ? be : 4'h0);
        chk(m_addr == {addr[31:2], 2'b00}, "R1", "start address", m_addr, {addr[31:2], 2'b00});
        forever begin
            @(negedge clk);
            m_trdy  = ($urandom % 100) < trdy_pct;
            q_afull = ($urandom % 100) < afull_pct;
            m_ack64 = ack;
            m_data  = {data_of(dw0 + 32'(idx) + 1), data_of(dw0 + 32'(idx))};
            #1;
            if (!m_frame) break;
            if (q_afull) begin
                chk(!q_wr && !m_irdy, "R9", "stall while almost full", {q_wr, m_irdy}, 0);
            end else begin
                chk(m_irdy, "R4", "no master wait state", m_irdy, 1);
            end
            if (q_wr) begin
                bit exp2 = use64 && (elen - idx >= 2);
                chk(q_wdw2 == exp2, exp2 ? "R4" : "R11", "double dword flag", q_wdw2, exp2);
                chk(q_wdata[31:0] == data_of(dw0 + 32'(idx)), "R11", "low dword",
                    q_wdata[31:0], data_of(dw0 + 32'(idx)));
                if (exp2) begin
                    chk(q_wdata[63:32] == data_of(dw0 + 32'(idx) + 1), "R4", "high dword",
                        q_wdata[63:32], data_of(dw0 + 32'(idx) + 1));
                end
                idx += exp2 ? 2 : 1;
            end
            cyc++;
            if (cyc > 20000) begin
                chk(1'b0, "R11", "transfer did not end", idx, elen);
                break;
            end
        end
        m_trdy = 1'b0; q_afull = 1'b0;
        chk(idx == elen, "R11", "dwords delivered", idx, elen);
        chk(req_ready == 1'b1, "R12", "ready after last dword", req_ready, 1);
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        chk(1'b0, "R12", "watchdog expired", 0, 1);
        if (!summary_done) begin
            summary_done = 1'b1;
            $display("CHECKS %0d ERRORS %0d", checks, errors);
        end
        $finish;
    end

    initial begin
        void'($urandom(32'd1234));
        repeat (3) @(negedge clk);
        #1;
        chk(req_ready && !m_frame && !m_start && !q_wr, "R12", "reset state",
            {req_ready, m_frame, m_start, q_wr}, 4'b1000);
        rst_n = 1'b1;
        @(negedge clk);
        #1;
        chk(req_ready && !m_frame, "R12", "idle after reset", {req_ready, m_frame}, 2'b10);

        run_txn(4'hE, 32'h0000_1014, 4'h3, 0, 0, 3, 0, 1, 0, 100, "R7");
        run_txn(4'hE, 32'h0000_1010, 4'h3, 0, 0, 3, 0, 1, 0, 100, "R7");
        run_txn(4'hC, 32'h0000_2000, 4'h5, 0, 0, 3, 0, 1, 0, 100, "R8");
        run_txn(4'h6, 32'h0000_2008, 4'h1, 1, 0, 2, 0, 1, 0, 100, "R8");
        run_txn(4'h6, 32'h0000_2008, 4'hA, 0, 0, 2, 0, 1, 0, 100, "R10");
        run_txn(4'h2, 32'h0000_2000, 4'h6, 1, 0, 5, 1, 1, 0, 100, "R1");
        run_txn(4'hC, 32'h0000_1FF0, 4'h0, 0, 0, 3, 1, 1, 0, 100, "R5");
        run_txn(4'hC, 32'h0000_1FF0, 4'h0, 0, 1, 3, 1, 1, 0, 90, "R6");
        run_txn(4'hC, 32'h0000_1FF0, 4'h0, 0, 1, 3, 0, 1, 0, 100, "R8");
        run_txn(4'hE, 32'h0000_3000, 4'h0, 0, 0, 0, 0, 1, 0, 100, "R11");
        run_txn(4'hC, 32'h0000_4000, 4'h0, 0, 0, 4, 0, 1, 50, 70, "R9");
        run_txn(4'hE, 32'h0000_5040, 4'h0, 0, 0, 4, 0, 0, 10, 80, "R4");
        run_txn(4'hC, 32'h0000_0FFC, 4'h0, 0, 0, 7, 1, 1, 0, 100, "R5");

        for (int i = 0; i < 40; i++) begin
            int          sel  = int'($urandom % 3);
            logic [3:0]  cmd  = (sel == 0) ? 4'h6 : ((sel == 1) ? 4'hC : 4'hE);
            logic [31:0] addr = $urandom & 32'hFFFF_FFFC;
            bit          flow = ($urandom % 5) == 0;
            int          kind = kind_of(cmd, 1'b0);
            bit          pf   = $urandom % 2;
            run_txn(cmd, addr, 4'($urandom), pf, $urandom % 2, int'($urandom % 8),
                    flow, $urandom % 2, 20, 80,
                    (kind_of(cmd, pf) == 0) ? "R10" : (flow ? "R5" : (kind == 1 ? "R7" : "R8")));
        end

        if (!summary_done) begin
            summary_done = 1'b1;
            $display("CHECKS %0d ERRORS %0d", checks, errors);
        end
        $finish;
    end

endmodule